// File: doc/BRIEF.md
# Stack Multiple-Register Push/Pop Sequencer

The block runs one 16-bit stack instruction that moves several registers at once. It keeps its own model of a sixteen-entry, 32-bit register file. Entry 13 is the stack pointer, entry 14 the return-address (link) register and entry 15 the program counter. A push stores any subset of R0–R7, and optionally the link register, to memory below the stack pointer. A pop reloads any subset of R0–R7, and optionally the program counter, from memory at the stack pointer.

Each word moves through a single request/ready memory port, one word per handshake. The stack pointer is moved as the instruction requires. When the program counter has been reloaded, a pipeline-flush pulse is raised together with completion. The rest of the core uses a side port to load and inspect the register file between instructions.

A push first lowers the stack pointer by the whole transfer size. It then stores upward in ascending register order, with the link register placed last. A pop reads upward from the stack pointer and moves the pointer up one word after each read. At completion the block reports one extra internal cycle for a pop and none for a push.

Top module: `stk_pushpop`

## Requirements
- R1: The instruction is decoded as follows. Bit 11 high selects a pop and low selects a push. Bit 8 adds one extra register: the link register (R14) on a push, or the program counter (R15) on a pop. Bits 7:0 are a mask in which bit i selects Ri. All other bits are ignored.
- R2: A pop reads the masked registers in ascending index order from ascending word addresses, starting at the stack pointer (R13). R13 increases by 4 after each word read. Registers not in the mask are left unchanged.
- R3: On a pop with bit 8 set, one more word is read after the masked registers and written to R15 with bit 0 cleared. R13 then rises by 4 once more, and `flush` is high in the same cycle as `done`. `flush` stays low on every push and on every pop without bit 8.
- R4: On a push, R13 is lowered by 4 × (mask population + bit 8) before the first store. The stores then run from the new R13 upward, one word apart, in ascending register order, with R14 last when bit 8 is set.
- R5: While `done` is high, `extra_cyc` reads 1 after a pop and 0 after a push. It is 0 in every other cycle.
- R6: While `mem_ready` is low, a request holds `mem_req`, `mem_addr`, `mem_we` (1 = store) and `mem_wdata` unchanged. The next access of the same instruction is presented in the cycle right after a handshake.
- R7: `done` is a one-cycle pulse. It comes in the cycle after the last handshake. When the mask is zero and bit 8 is clear, it comes in the cycle after the instruction is accepted, with no memory access and R13 unchanged.
- R8: Reset is synchronous and active-low. It returns the sequencer to idle, with `busy`, `done`, `flush` and `mem_req` low, and it does not change register-file contents.
- R9: `instr_valid` is accepted only while `busy` is low. A side-port write (`rf_wr_en`) takes effect only while `busy` is low and is otherwise ignored. `rf_rd_data` always shows the entry chosen by `rf_rd_idx` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction present; accepted when `busy` is low |
| instr | input | 16 | Instruction word |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-cycle completion pulse |
| flush | output | 1 | Pipeline flush, raised with `done` after a PC reload |
| extra_cyc | output | 2 | Extra internal cycles to be charged, valid with `done` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, sampled on the handshake |
| mem_ready | input | 1 | Completes the access in this cycle |
| rf_wr_en | input | 1 | Side-port register write enable |
| rf_wr_idx | input | 4 | Side-port write index |
| rf_wr_data | input | 32 | Side-port write data |
| rf_rd_idx | input | 4 | Side-port read index |
| rf_rd_data | output | 32 | Side-port read data (combinational) |

## Verification
The bench builds the block with its default parameters: a 32-bit word, sixteen registers and an eight-bit register mask. With these values every mask and extra-flag combination, 512 per direction, can be run as both a push and a pop. The memory model inserts zero, one or two wait states, rotating from one access to the next, so held requests are exercised across all of those patterns. Directed cases add an empty mask, a side-port write and a second instruction issued while busy, and a reset in the middle of a transfer.

// File: rtl/stk_pkg.sv
// Shared types for the stack push/pop sequencer.
// Assumes: one instruction in flight at a time.
package stk_pkg;

    // Sequencer phases: waiting, moving words, reporting completion
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_XFER = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_t;

endpackage

// File: rtl/stk_decode.sv
// Instruction field decoder: splits the word into direction, extra-register
// flag and register mask, and counts the words the instruction moves.
// Assumes: field positions are supplied as parameters by the parent.
module stk_decode #(
    parameter int IW      = 16,
    parameter int LIST_W  = 8,
    parameter int POP_BIT = 11,
    parameter int EXT_BIT = 8,
    parameter int CNT_W   = 4
) (
    input  logic [IW-1:0]     instr,
    output logic              is_pop,
    output logic              extra,
    output logic [LIST_W-1:0] mask,
    output logic [CNT_W-1:0]  count
);

    assign is_pop = instr[POP_BIT];
    assign extra  = instr[EXT_BIT];
    assign mask   = instr[LIST_W-1:0];

    // Population count of the mask plus the extra register
    always_comb begin
        count = CNT_W'(extra);
        for (int i = 0; i < LIST_W; i++) begin
            count = count + CNT_W'(mask[i]);
        end
    end

endmodule

// File: rtl/stk_pick.sv
// Lowest-set-bit picker: reports whether any bit of the remaining mask is
// set and the index of the lowest one.
// Assumes: LIST_W is at least 2.
module stk_pick #(
    parameter int LIST_W = 8,
    parameter int SEL_W  = $clog2(LIST_W)
) (
    input  logic [LIST_W-1:0] mask,
    output logic              any,
    output logic [SEL_W-1:0]  idx
);

    // Scan from the top so the lowest set bit wins
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = LIST_W - 1; i >= 0; i--) begin
            if (mask[i]) begin
                any = 1'b1;
                idx = SEL_W'(i);
            end
        end
    end

endmodule

// File: rtl/stk_regfile.sv
// Register file model with two write ports and two read ports. Port B (stack
// pointer updates) wins over port A when both hit the same entry.
// Assumes: no reset; contents persist across sequencer reset.
module stk_regfile #(
    parameter int NREG   = 16,
    parameter int XLEN   = 32,
    parameter int SP_IDX = 13,
    parameter int IDX_W  = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             a_en,
    input  logic [IDX_W-1:0] a_idx,
    input  logic [XLEN-1:0]  a_data,
    input  logic             b_en,
    input  logic [IDX_W-1:0] b_idx,
    input  logic [XLEN-1:0]  b_data,
    input  logic [IDX_W-1:0] r0_idx,
    output logic [XLEN-1:0]  r0_data,
    input  logic [IDX_W-1:0] r1_idx,
    output logic [XLEN-1:0]  r1_data,
    output logic [XLEN-1:0]  sp_data
);

    logic [XLEN-1:0] regs [NREG];
    logic [NREG-1:0] hit_a;
    logic [NREG-1:0] hit_b;

    // Per-entry write-enable decode
    for (genvar g = 0; g < NREG; g++) begin : g_dec
        assign hit_a[g] = a_en && (a_idx == IDX_W'(g));
        assign hit_b[g] = b_en && (b_idx == IDX_W'(g));
    end

    // Entry update with port B priority
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (hit_b[i]) begin
                regs[i] <= b_data;
            end else if (hit_a[i]) begin
                regs[i] <= a_data;
            end
        end
    end

    assign r0_data = regs[r0_idx];
    assign r1_data = regs[r1_idx];
    assign sp_data = regs[SP_IDX];

endmodule

// File: rtl/stk_pushpop.sv
// Stack multiple-register sequencer. Accepts one push/pop instruction, moves
// one word per memory handshake, keeps the stack pointer in the register file
// model, and signals completion, flush and extra-cycle count.
// Assumes: the stack pointer is word aligned; memory answers every request.
module stk_pushpop
    import stk_pkg::*;
#(
    parameter int XLEN          = 32,
    parameter int NREG          = 16,
    parameter int IW            = 16,
    parameter int LIST_W        = 8,
    parameter int SP_IDX        = 13,
    parameter int LR_IDX        = 14,
    parameter int PC_IDX        = 15,
    parameter int POP_BIT       = 11,
    parameter int EXT_BIT       = 8,
    parameter int CYC_W         = 2,
    parameter int POP_EXTRA_CYC = 1,
    parameter int IDX_W         = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic [IW-1:0]    instr,
    output logic             busy,
    output logic             done,
    output logic             flush,
    output logic [CYC_W-1:0] extra_cyc,
    output logic             mem_req,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic [XLEN-1:0]  mem_rdata,
    input  logic             mem_ready,
    input  logic             rf_wr_en,
    input  logic [IDX_W-1:0] rf_wr_idx,
    input  logic [XLEN-1:0]  rf_wr_data,
    input  logic [IDX_W-1:0] rf_rd_idx,
    output logic [XLEN-1:0]  rf_rd_data
);

    localparam int CNT_W   = $clog2(LIST_W + 2);
    localparam int SEL_W   = $clog2(LIST_W);
    localparam int BYTE_SH = $clog2(XLEN / 8);
    localparam logic [XLEN-1:0] WORD_STEP = XLEN'(XLEN / 8);

    seq_state_t        state_q;
    logic              pop_q;
    logic              extra_q;
    logic [LIST_W-1:0] mask_q;
    logic [XLEN-1:0]   addr_q;
    logic              pc_loaded_q;

    logic              dec_pop;
    logic              dec_extra;
    logic [LIST_W-1:0] dec_mask;
    logic [CNT_W-1:0]  dec_count;
    logic              pick_any;
    logic [SEL_W-1:0]  pick_idx;
    logic [IDX_W-1:0]  cur_idx;
    logic              accept;
    logic              hs;
    logic              last;
    logic [XLEN-1:0]   sp_val;
    logic [XLEN-1:0]   xfer_size;
    logic [XLEN-1:0]   rd_word;

    logic              a_en;
    logic [IDX_W-1:0]  a_idx;
    logic [XLEN-1:0]   a_data;
    logic              b_en;
    logic [XLEN-1:0]   b_data;

    stk_decode #(
        .IW(IW), .LIST_W(LIST_W), .POP_BIT(POP_BIT),
        .EXT_BIT(EXT_BIT), .CNT_W(CNT_W)
    ) dec_i (
        .instr (instr),
        .is_pop(dec_pop),
        .extra (dec_extra),
        .mask  (dec_mask),
        .count (dec_count)
    );

    stk_pick #(.LIST_W(LIST_W), .SEL_W(SEL_W)) pick_i (
        .mask(mask_q),
        .any (pick_any),
        .idx (pick_idx)
    );

    stk_regfile #(
        .NREG(NREG), .XLEN(XLEN), .SP_IDX(SP_IDX), .IDX_W(IDX_W)
    ) rf_i (
        .clk    (clk),
        .a_en   (a_en),
        .a_idx  (a_idx),
        .a_data (a_data),
        .b_en   (b_en),
        .b_idx  (IDX_W'(SP_IDX)),
        .b_data (b_data),
        .r0_idx (cur_idx),
        .r0_data(rd_word),
        .r1_idx (rf_rd_idx),
        .r1_data(rf_rd_data),
        .sp_data(sp_val)
    );

    // Handshake and entry selection for the current word
    always_comb begin
        accept    = (state_q == SEQ_IDLE) && instr_valid;
        hs        = (state_q == SEQ_XFER) && mem_ready;
        xfer_size = XLEN'(dec_count) << BYTE_SH;
        if (pick_any) begin
            cur_idx = IDX_W'(pick_idx);
            last    = ((mask_q & (mask_q - LIST_W'(1))) == '0) && !extra_q;
        end else begin
            cur_idx = pop_q ? IDX_W'(PC_IDX) : IDX_W'(LR_IDX);
            last    = 1'b1;
        end
    end

    // Register-file write steering: loads and side port on A, stack pointer on B
    always_comb begin
        a_en   = 1'b0;
        a_idx  = rf_wr_idx;
        a_data = rf_wr_data;
        if (hs && pop_q) begin
            a_en   = 1'b1;
            a_idx  = cur_idx;
            a_data = (cur_idx == IDX_W'(PC_IDX)) ? (mem_rdata & ~XLEN'(1)) : mem_rdata;
        end else if ((state_q == SEQ_IDLE) && rf_wr_en) begin
            a_en = 1'b1;
        end
        b_en   = 1'b0;
        b_data = sp_val + WORD_STEP;
        if (accept && !dec_pop && (dec_count != '0)) begin
            b_en   = 1'b1;
            b_data = sp_val - xfer_size;
        end else if (hs && pop_q) begin
            b_en = 1'b1;
        end
    end

    // Sequencer state and transfer bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= SEQ_IDLE;
            pc_loaded_q <= 1'b0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (accept) begin
                        pop_q       <= dec_pop;
                        extra_q     <= dec_extra;
                        mask_q      <= dec_mask;
                        pc_loaded_q <= 1'b0;
                        addr_q      <= dec_pop ? sp_val : (sp_val - xfer_size);
                        state_q     <= (dec_count == '0) ? SEQ_DONE : SEQ_XFER;
                    end
                end
                SEQ_XFER: begin
                    if (mem_ready) begin
                        addr_q <= addr_q + WORD_STEP;
                        if (pick_any) begin
                            mask_q <= mask_q & (mask_q - LIST_W'(1));
                        end else begin
                            extra_q <= 1'b0;
                        end
                        if (pop_q && (cur_idx == IDX_W'(PC_IDX))) begin
                            pc_loaded_q <= 1'b1;
                        end
                        if (last) begin
                            state_q <= SEQ_DONE;
                        end
                    end
                end
                default: begin
                    state_q <= SEQ_IDLE;
                end
            endcase
        end
    end

    assign busy      = (state_q != SEQ_IDLE);
    assign done      = (state_q == SEQ_DONE);
    assign flush     = done && pc_loaded_q;
    assign extra_cyc = (done && pop_q) ? CYC_W'(POP_EXTRA_CYC) : '0;
    assign mem_req   = (state_q == SEQ_XFER);
    assign mem_we    = !pop_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = rd_word;

endmodule

// File: rtl/stk_pushpop_chk.sv
// Property checker for the stack sequencer, bound to every instance.
// Assumes: clocked properties are disabled while reset is asserted.
module stk_pushpop_chk #(
    parameter int XLEN  = 32,
    parameter int CYC_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             flush,
    input logic [CYC_W-1:0] extra_cyc,
    input logic             mem_req,
    input logic             mem_we,
    input logic [XLEN-1:0]  mem_addr,
    input logic [XLEN-1:0]  mem_wdata,
    input logic             mem_ready
);

    localparam logic [XLEN-1:0] WSTEP = XLEN'(XLEN / 8);

    logic rst_seen_q = 1'b0;

    // Remember that reset was applied at the previous edge
    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    // R6: a waiting request holds all its fields
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R6: a following access of the same instruction is one word higher
    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> (!mem_req || (mem_addr == $past(mem_addr) + WSTEP)));

    // R7: completion lasts one cycle and has no access beside it
    a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_req && busy));

    // R3: flush only with completion of a pop
    a_r3_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (done && !mem_we));

    // R5: extra cycles only reported with done, and never after a push
    a_r5_push_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((extra_cyc != '0) |-> done) and ((done && mem_we) |-> (extra_cyc == '0)));

    // R9: no access unless an instruction is in progress
    a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R8: the edge after reset leaves the sequencer idle
    always_ff @(posedge clk) begin
        if (rst_seen_q) begin
            a_r8_idle: assert (!busy && !mem_req && !done && !flush);
        end
    end

endmodule

bind stk_pushpop stk_pushpop_chk #(.XLEN(XLEN), .CYC_W(CYC_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .flush    (flush),
    .extra_cyc(extra_cyc),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_ready(mem_ready)
);

// File: tb/stk_pushpop_tb_top.sv
`timescale 1ns/1ps
module stk_pushpop_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic        busy, done, flush;
    logic [1:0]  extra_cyc;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready = 1'b0;
    logic        rf_wr_en = 1'b0;
    logic [3:0]  rf_wr_idx = '0;
    logic [31:0] rf_wr_data = '0;
    logic [3:0]  rf_rd_idx = '0;
    logic [31:0] rf_rd_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    logic [31:0] mem [0:1023];
    logic [31:0] log_addr [0:15];
    int acc_n = 0;
    int hs_total = 0;
    int wcnt = 0;
    int lat_mode = 0;
    int done_seen = 0;
    int done_cyc = 0;
    int accept_cyc = 0;
    int last_hs_cyc = 0;
    bit flush_at_done = 0;
    logic [1:0] xc_at_done = '0;
    int hold_err = 0;
    int gap_err = 0;
    bit prev_wait = 0;
    logic [31:0] p_addr, p_wdata;
    logic p_we;

    always #2.5 clk = ~clk;

    stk_pushpop dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .busy(busy), .done(done), .flush(flush), .extra_cyc(extra_cyc),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
        .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data)
    );

    assign mem_rdata = mem[mem_addr[11:2]];

    // Memory ready generation, away from the active edge
    always @(negedge clk) begin
        if (!mem_req) mem_ready = 1'b0;
        else if (wcnt == 0) mem_ready = 1'b1;
        else begin mem_ready = 1'b0; wcnt = wcnt - 1; end
    end

    // Memory model and bus monitor
    always @(posedge clk) begin
        if (prev_wait) begin
            if (!(mem_req && mem_addr == p_addr && mem_we == p_we && mem_wdata == p_wdata))
                hold_err++;
        end
        prev_wait = mem_req && !mem_ready;
        p_addr = mem_addr; p_we = mem_we; p_wdata = mem_wdata;
        if (busy && !mem_req && !done) gap_err++;
        if (instr_valid && !busy && rst_n) accept_cyc = cyc;
        if (mem_req && mem_ready && rst_n) begin
            if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
            if (acc_n < 16) log_addr[acc_n] = mem_addr;
            acc_n++;
            hs_total++;
            last_hs_cyc = cyc;
            wcnt = (lat_mode == 0) ? 0 : (hs_total % 3);
        end
        if (done && rst_n) begin
            done_seen++;
            done_cyc = cyc;
            flush_at_done = flush;
            xc_at_done = extra_cyc;
        end
        cyc++;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic rf_write(input int idx, input logic [31:0] val);
        @(negedge clk);
        rf_wr_en = 1'b1; rf_wr_idx = 4'(idx); rf_wr_data = val;
        @(negedge clk);
        rf_wr_en = 1'b0;
    endtask

    task automatic rf_read(input int idx, output logic [31:0] val);
        @(negedge clk);
        rf_rd_idx = 4'(idx);
        #1 val = rf_rd_data;
    endtask

    task automatic run_instr(input logic [15:0] iw);
        int d0;
        int lim;
        @(negedge clk);
        acc_n = 0;
        d0 = done_seen;
        instr_valid = 1'b1; instr = iw;
        @(negedge clk);
        instr_valid = 1'b0;
        lim = 0;
        while (done_seen == d0 && lim < 300) begin
            @(negedge clk);
            lim++;
        end
        if (done_seen == d0) check(1'b0, "R7 timeout waiting for done", 0, 1);
    endtask

    function automatic logic [31:0] pat(input int i, input int m);
        return 32'hA000_0000 ^ (32'(m) << 8) ^ (32'(i) * 32'h0101_0011);
    endfunction

    function automatic logic [31:0] pv(input int k, input int m);
        return 32'h5000_0001 ^ (32'(m) << 12) ^ (32'(k) << 4);
    endfunction

    // Global watchdog
    initial begin
        #900000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 1024; i++) mem[i] = 32'(i);
        repeat (3) @(negedge clk);
        // R8: reset state
        check(!busy && !done && !flush && !mem_req, "R8 idle after reset", {28'd0, busy, done, flush, mem_req}, 0);
        rst_n = 1'b1;

        for (int e = 0; e < 2; e++) begin
            for (int m = 0; m < 256; m++) begin
                int n;
                int k;
                logic [31:0] base;
                n = $countones(m) + e;
                lat_mode = m % 3;
                // ---- push ----
                for (int i = 0; i < 8; i++) rf_write(i, pat(i, m));
                rf_write(14, pat(14, m));
                rf_write(13, 32'h800);
                run_instr(16'hB400 | 16'(e << 8) | 16'(m));
                base = 32'h800 - 32'(4 * n);
                check(acc_n == n, "R4 push access count", acc_n, n);
                if (n == 0) check(done_cyc == accept_cyc + 1, "R7 empty done timing", done_cyc, accept_cyc + 1);
                else check(done_cyc == last_hs_cyc + 1, "R7 done after last access", done_cyc, last_hs_cyc + 1);
                check(xc_at_done == 2'd0, "R5 push extra cycles", xc_at_done, 0);
                check(!flush_at_done, "R3 no flush on push", flush_at_done, 0);
                rf_read(13, v);
                check(v == base, "R4 push SP", v, base);
                k = 0;
                for (int i = 0; i < 8; i++) if (m[i]) begin
                    check(mem[(base >> 2) + k] == pat(i, m), "R4 push data order", mem[(base >> 2) + k], pat(i, m));
                    check(log_addr[k] == base + 32'(4 * k), "R4 push address order", log_addr[k], base + 32'(4 * k));
                    k++;
                end
                if (e == 1) begin
                    check(mem[(base >> 2) + k] == pat(14, m), "R1 R4 link register stored last", mem[(base >> 2) + k], pat(14, m));
                    check(log_addr[k] == base + 32'(4 * k), "R4 link address", log_addr[k], base + 32'(4 * k));
                end
                // ---- pop ----
                for (int i = 0; i < 8; i++) rf_write(i, 32'hDEAD_0000 + 32'(i));
                rf_write(15, 32'h0000_1230);
                rf_write(13, 32'h600);
                for (int j = 0; j < 10; j++) mem[32'h180 + j] = pv(j, m);
                run_instr(16'hBC00 | 16'(e << 8) | 16'(m));
                check(acc_n == n, "R2 pop access count", acc_n, n);
                if (n == 0) check(done_cyc == accept_cyc + 1, "R7 empty pop done timing", done_cyc, accept_cyc + 1);
                else check(done_cyc == last_hs_cyc + 1, "R7 pop done after last access", done_cyc, last_hs_cyc + 1);
                check(xc_at_done == 2'd1, "R5 pop extra cycles", xc_at_done, 1);
                check(flush_at_done == e[0], "R3 flush on PC reload", flush_at_done, e);
                rf_read(13, v);
                check(v == 32'h600 + 32'(4 * n), "R2 pop SP", v, 32'h600 + 32'(4 * n));
                k = 0;
                for (int i = 0; i < 8; i++) begin
                    rf_read(i, v);
                    if (m[i]) begin
                        check(v == pv(k, m), "R2 pop data order", v, pv(k, m));
                        check(log_addr[k] == 32'h600 + 32'(4 * k), "R2 pop address order", log_addr[k], 32'h600 + 32'(4 * k));
                        k++;
                    end else begin
                        check(v == 32'hDEAD_0000 + 32'(i), "R2 unmasked register kept", v, 32'hDEAD_0000 + 32'(i));
                    end
                end
                rf_read(15, v);
                if (e == 1) check(v == (pv(k, m) & ~32'd1), "R3 PC loaded with bit 0 clear", v, pv(k, m) & ~32'd1);
                else check(v == 32'h1230, "R1 PC untouched without extra bit", v, 32'h1230);
            end
        end
        check(hold_err == 0, "R6 request held while not ready", hold_err, 0);
        check(gap_err == 0, "R6 no idle cycle between accesses", gap_err, 0);

        // R9: side-port write and new instruction ignored while busy
        lat_mode = 1;
        for (int i = 0; i < 8; i++) rf_write(i, pat(i, 7));
        rf_write(13, 32'h800);
        @(negedge clk);
        acc_n = 0;
        instr_valid = 1'b1; instr = 16'hB4FF;
        @(negedge clk);
        instr_valid = 1'b0;
        @(negedge clk);
        rf_wr_en = 1'b1; rf_wr_idx = 4'd0; rf_wr_data = 32'h1111_2222;
        instr_valid = 1'b1; instr = 16'hBC01;
        @(negedge clk);
        rf_wr_en = 1'b0; instr_valid = 1'b0;
        begin
            int lim = 0;
            while (!done && lim < 100) begin @(negedge clk); lim++; end
        end
        repeat (4) @(negedge clk);
        check(acc_n == 8, "R9 busy instruction ignored", acc_n, 8);
        check(!busy, "R9 no second instruction started", busy, 0);
        rf_read(0, v);
        check(v == pat(0, 7), "R9 side write ignored while busy", v, pat(0, 7));
        rf_read(13, v);
        check(v == 32'h7E0, "R9 SP after single push", v, 32'h7E0);

        // R8: reset in mid transfer keeps register contents
        lat_mode = 1;
        rf_write(3, 32'hCAFE_0003);
        rf_write(13, 32'h800);
        @(negedge clk);
        instr_valid = 1'b1; instr = 16'hB4FF;
        @(negedge clk);
        instr_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(!busy && !mem_req && !done, "R8 reset aborts transfer", {29'd0, busy, mem_req, done}, 0);
        rst_n = 1'b1;
        wcnt = 0;
        rf_read(3, v);
        check(v == 32'hCAFE_0003, "R8 register kept through reset", v, 32'hCAFE_0003);
        rf_read(13, v);
        check(v == 32'h7E0, "R8 SP kept through reset", v, 32'h7E0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule